// File: doc/BRIEF.md
# Sleep State Transition Sequencer

This block puts a system into one of two sleep states and brings it back. Software issues a single write to the sleep-control port with a 3-bit sleep-type code and an enable bit. A supported code starts an ordered shutdown. The light-sleep code gates every system clock, puts memory into self-refresh and then removes CPU and cache power. The deep-sleep code puts memory into self-refresh, isolates the devices that hold memory, and then drops CPU power, the auxiliary power domain and the system clocks. The real-time clock is never gated by this block.

Each step holds for at least `MIN_CYC` cycles. A step that waits on a handshake holds until its acknowledge (self-refresh acknowledge or power-good) also arrives. A wake event runs the steps in reverse order. Power comes back first. The CPU stays in reset until the last step and is then released, so it starts from its boot vector, while memory and core-logic context are kept. A wake event that arrives during entry is remembered and acted on as soon as the sleep state is reached. A 3-bit status output and a sticky wake flag report progress.

Top module: `slp_seq`

## Requirements
- R1: A sequence starts only when a write (`ctl_wr_i`) carries `ctl_en_i`=1 and a supported code (light `LIGHT_CODE`=2, deep `DEEP_CODE`=3 by default) while status is working. The entering status appears on the second clock edge after the write. The enable is taken for that one write only. Writes with enable 0, with any other code, or made while not working have no effect.
- R2: Light entry: `clk_stop_o` rises first. `mem_sr_o` rises `MIN_CYC` cycles later. `cpu_pwr_o` falls max(`MIN_CYC`, cycles until `sr_ack_i` is seen high) cycles after that.
- R3: Light sleep (status 2) is reached `MIN_CYC` cycles after CPU power-off. It holds clocks stopped, memory in self-refresh, CPU unpowered and the auxiliary domain powered.
- R4: `cpu_rst_o` is high whenever `cpu_pwr_o` is low. It stays high from CPU power-off until the final exit step.
- R5: Deep entry: `mem_sr_o` rises first. `iso_o` rises once the self-refresh acknowledge is seen and `MIN_CYC` cycles have passed. `MIN_CYC` cycles later, `cpu_pwr_o`, `aux_pwr_o` and the clocks are all switched off on the same edge.
- R6: Deep sleep (status 3) is reached `MIN_CYC` cycles after power-off and keeps `aux_pwr_o` low. `wake_light_i` is ignored in deep sleep but wakes light sleep. `wake_any_i` wakes either state.
- R7: A step with no handshake lasts exactly `MIN_CYC` cycles. A step with a handshake lasts max(`MIN_CYC`, acknowledge latency + 1) cycles.
- R8: Exit order: power on (`cpu_pwr_o`, `aux_pwr_o`) on the cycle after the wake. Clocks restart after power-good and `MIN_CYC` cycles. `MIN_CYC` cycles after that, self-refresh is dropped. Isolation drops once the acknowledge falls. `cpu_rst_o` is released `MIN_CYC` cycles after that.
- R9: A wake during entry lets entry finish. The sleep status shows for exactly one cycle, and then exit begins.
- R10: Status codes are 0 working, 1 entering, 2 light sleep, 3 deep sleep, 4 exiting. `wake_sts_o` rises with the exiting status and clears when the next sequence starts.
- R11: In working status every output is idle: clocks running, no self-refresh, CPU powered and out of reset, no isolation, auxiliary domain on. Wake inputs have no effect there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on sequencer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_wr_i | input | 1 | Sleep-control write strobe |
| ctl_type_i | input | TYPE_W | Sleep-type code carried by the write |
| ctl_en_i | input | 1 | Sleep enable carried by the write |
| wake_any_i | input | 1 | Wake source valid in both sleep states |
| wake_light_i | input | 1 | Wake source valid only in light sleep |
| sr_ack_i | input | 1 | Memory self-refresh acknowledge (level) |
| pwr_good_i | input | 1 | CPU power domain good |
| clk_stop_o | output | 1 | Gate all system clocks |
| mem_sr_o | output | 1 | Memory self-refresh request |
| cpu_pwr_o | output | 1 | CPU and cache power enable |
| cpu_rst_o | output | 1 | CPU reset |
| iso_o | output | 1 | Isolation for memory-holding devices |
| aux_pwr_o | output | 1 | Auxiliary power domain enable |
| state_o | output | 3 | Sequencer status code |
| wake_sts_o | output | 1 | Sticky wake flag |

## Verification
The assertions assume that `sr_ack_i` is a level that follows `mem_sr_o`, and that `pwr_good_i` follows `cpu_pwr_o`, each after some delay. The stimulus meets this with delay-line models of the memory and the power switch, and it sweeps both delays over several values for both sleep types. Wake pulses are driven only after the sleep or entering status has been observed. Every CPU power-off period lasts longer than the power-good delay, so a stale power-good is never seen at exit.

// File: rtl/slp_seq_pkg.sv
package slp_seq_pkg;
  localparam int STS_W = 3;

  typedef enum logic [3:0] {
    S_RUN, S_L_CLK, S_L_SR, S_L_CPU, S_L_SLP,
    S_D_SR, S_D_ISO, S_D_OFF, S_D_SLP,
    S_X_PWR, S_X_CLK, S_X_SR, S_X_ISO
  } seq_st_e;

  typedef enum logic [STS_W-1:0] {
    STS_WORK  = 3'd0,
    STS_ENTER = 3'd1,
    STS_LIGHT = 3'd2,
    STS_DEEP  = 3'd3,
    STS_EXIT  = 3'd4
  } sts_e;
endpackage

// File: rtl/slp_seq_cmd.sv
module slp_seq_cmd #(
  parameter int              TYPE_W     = 3,
  parameter logic [TYPE_W-1:0] LIGHT_CODE = 3'd2,
  parameter logic [TYPE_W-1:0] DEEP_CODE  = 3'd3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic              en_i,
  input  logic              idle_i,
  output logic              start_o,
  output logic              deep_o
);
  logic              en_q;
  logic [TYPE_W-1:0] typ_q;

  // enable lives one cycle: set by a write, cleared once sampled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      typ_q <= '0;
    end else begin
      en_q <= wr_i & en_i;
      if (wr_i) typ_q <= type_i;
    end
  end

  logic code_ok;
  assign code_ok = (typ_q == LIGHT_CODE) || (typ_q == DEEP_CODE);
  assign start_o = en_q & code_ok & idle_i;
  assign deep_o  = (typ_q == DEEP_CODE);
endmodule

// File: rtl/slp_seq_tmr.sv
module slp_seq_tmr #(
  parameter int MIN_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic done_o
);
  if (MIN_CYC <= 1) begin : g_nowait
    logic unused_w;
    assign unused_w = ^{clk_i, rst_ni, clr_i};
    assign done_o   = 1'b1;
  end else begin : g_cnt
    localparam int          CW   = $clog2(MIN_CYC);
    localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            cnt_q <= '0;
      else if (clr_i)         cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = (cnt_q == LAST);
  end
endmodule

// File: rtl/slp_seq_fsm.sv
module slp_seq_fsm
  import slp_seq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    deep_cmd_i,
  input  logic    step_done_i,
  input  logic    sr_ack_i,
  input  logic    pwr_good_i,
  input  logic    wake_any_i,
  input  logic    wake_light_i,
  output seq_st_e st_o,
  output logic    deep_o,
  output logic    step_clr_o,
  output logic    wake_sts_o
);
  seq_st_e st_q, st_d;
  logic    deep_q, pend_q, wsts_q;
  logic    wake_hit, in_entry, asleep;

  assign wake_hit = wake_any_i | (wake_light_i & ~deep_q);
  assign in_entry = st_q inside {S_L_CLK, S_L_SR, S_L_CPU, S_D_SR, S_D_ISO, S_D_OFF};
  assign asleep   = st_q inside {S_L_SLP, S_D_SLP};

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_RUN:   if (start_i) st_d = deep_cmd_i ? S_D_SR : S_L_CLK;
      S_L_CLK: if (step_done_i) st_d = S_L_SR;
      S_L_SR:  if (step_done_i && sr_ack_i) st_d = S_L_CPU;
      S_L_CPU: if (step_done_i) st_d = S_L_SLP;
      S_D_SR:  if (step_done_i && sr_ack_i) st_d = S_D_ISO;
      S_D_ISO: if (step_done_i) st_d = S_D_OFF;
      S_D_OFF: if (step_done_i) st_d = S_D_SLP;
      S_L_SLP,
      S_D_SLP: if (wake_hit || pend_q) st_d = S_X_PWR;
      S_X_PWR: if (step_done_i && pwr_good_i) st_d = S_X_CLK;
      S_X_CLK: if (step_done_i) st_d = S_X_SR;
      S_X_SR:  if (step_done_i && !sr_ack_i) st_d = S_X_ISO;
      S_X_ISO: if (step_done_i) st_d = S_RUN;
      default: st_d = S_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_RUN;
      deep_q <= 1'b0;
      pend_q <= 1'b0;
      wsts_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == S_RUN && start_i) deep_q <= deep_cmd_i;
      // wake seen mid-entry is held until the sleep state is reached
      if (st_d == S_X_PWR)          pend_q <= 1'b0;
      else if (in_entry && wake_hit) pend_q <= 1'b1;
      if (st_q == S_RUN && start_i)        wsts_q <= 1'b0;
      else if (asleep && st_d == S_X_PWR)  wsts_q <= 1'b1;
    end
  end

  assign st_o       = st_q;
  assign deep_o     = deep_q;
  assign step_clr_o = (st_d != st_q);
  assign wake_sts_o = wsts_q;
endmodule

// File: rtl/slp_seq_out.sv
module slp_seq_out
  import slp_seq_pkg::*;
(
  input  seq_st_e          st_i,
  input  logic             deep_i,
  output logic             clk_stop_o,
  output logic             mem_sr_o,
  output logic             cpu_pwr_o,
  output logic             cpu_rst_o,
  output logic             iso_o,
  output logic             aux_pwr_o,
  output logic [STS_W-1:0] sts_o
);
  sts_e sts;

  always_comb begin
    clk_stop_o = st_i inside {S_L_CLK, S_L_SR, S_L_CPU, S_L_SLP, S_D_OFF, S_D_SLP, S_X_PWR};
    mem_sr_o   = st_i inside {S_L_SR, S_L_CPU, S_L_SLP, S_D_SR, S_D_ISO, S_D_OFF, S_D_SLP,
                              S_X_PWR, S_X_CLK};
    cpu_pwr_o  = !(st_i inside {S_L_CPU, S_L_SLP, S_D_OFF, S_D_SLP});
    cpu_rst_o  = st_i inside {S_L_CPU, S_L_SLP, S_D_OFF, S_D_SLP, S_X_PWR, S_X_CLK, S_X_SR,
                              S_X_ISO};
    iso_o      = (st_i inside {S_D_ISO, S_D_OFF, S_D_SLP}) ||
                 (deep_i && (st_i inside {S_X_PWR, S_X_CLK, S_X_SR}));
    aux_pwr_o  = !(st_i inside {S_D_OFF, S_D_SLP});
    unique case (st_i)
      S_RUN:                      sts = STS_WORK;
      S_L_SLP:                    sts = STS_LIGHT;
      S_D_SLP:                    sts = STS_DEEP;
      S_X_PWR, S_X_CLK, S_X_SR,
      S_X_ISO:                    sts = STS_EXIT;
      default:                    sts = STS_ENTER;
    endcase
  end

  assign sts_o = sts;
endmodule

// File: rtl/slp_seq.sv
module slp_seq
  import slp_seq_pkg::*;
#(
  parameter int                TYPE_W     = 3,
  parameter logic [TYPE_W-1:0] LIGHT_CODE = 3'd2,
  parameter logic [TYPE_W-1:0] DEEP_CODE  = 3'd3,
  parameter int                MIN_CYC    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctl_wr_i,
  input  logic [TYPE_W-1:0] ctl_type_i,
  input  logic              ctl_en_i,
  input  logic              wake_any_i,
  input  logic              wake_light_i,
  input  logic              sr_ack_i,
  input  logic              pwr_good_i,
  output logic              clk_stop_o,
  output logic              mem_sr_o,
  output logic              cpu_pwr_o,
  output logic              cpu_rst_o,
  output logic              iso_o,
  output logic              aux_pwr_o,
  output logic [2:0]        state_o,
  output logic              wake_sts_o
);
  seq_st_e st;
  logic    start, deep_cmd, deep_q, step_done, step_clr;

  slp_seq_cmd #(
    .TYPE_W(TYPE_W), .LIGHT_CODE(LIGHT_CODE), .DEEP_CODE(DEEP_CODE)
  ) u_cmd (
    .clk_i, .rst_ni,
    .wr_i    (ctl_wr_i),
    .type_i  (ctl_type_i),
    .en_i    (ctl_en_i),
    .idle_i  (st == S_RUN),
    .start_o (start),
    .deep_o  (deep_cmd)
  );

  slp_seq_tmr #(.MIN_CYC(MIN_CYC)) u_tmr (
    .clk_i, .rst_ni,
    .clr_i  (step_clr),
    .done_o (step_done)
  );

  slp_seq_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i      (start),
    .deep_cmd_i   (deep_cmd),
    .step_done_i  (step_done),
    .sr_ack_i     (sr_ack_i),
    .pwr_good_i   (pwr_good_i),
    .wake_any_i   (wake_any_i),
    .wake_light_i (wake_light_i),
    .st_o         (st),
    .deep_o       (deep_q),
    .step_clr_o   (step_clr),
    .wake_sts_o   (wake_sts_o)
  );

  slp_seq_out u_out (
    .st_i       (st),
    .deep_i     (deep_q),
    .clk_stop_o (clk_stop_o),
    .mem_sr_o   (mem_sr_o),
    .cpu_pwr_o  (cpu_pwr_o),
    .cpu_rst_o  (cpu_rst_o),
    .iso_o      (iso_o),
    .aux_pwr_o  (aux_pwr_o),
    .sts_o      (state_o)
  );
endmodule

// File: rtl/slp_seq_chk.sv
module slp_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sr_ack_i,
  input logic       pwr_good_i,
  input logic       clk_stop_o,
  input logic       mem_sr_o,
  input logic       cpu_pwr_o,
  input logic       cpu_rst_o,
  input logic       iso_o,
  input logic       aux_pwr_o,
  input logic [2:0] state_o,
  input logic       wake_sts_o
);
  AST_CPU_OFF_AFTER_SR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_pwr_o) |-> mem_sr_o && clk_stop_o); // R2
  AST_LIGHT_RAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd2 |-> clk_stop_o && mem_sr_o && aux_pwr_o && !cpu_pwr_o); // R3
  AST_RST_UNPOWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_pwr_o |-> cpu_rst_o); // R4
  AST_ISO_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iso_o) |-> mem_sr_o && $past(sr_ack_i)); // R5
  AST_DEEP_RAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd3 |-> !aux_pwr_o && iso_o && mem_sr_o && clk_stop_o); // R6
  AST_CLK_AFTER_PG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_stop_o) |-> cpu_pwr_o && $past(pwr_good_i)); // R8
  AST_SR_DROP_CLK_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_sr_o) |-> !clk_stop_o); // R8
  AST_RST_RELEASE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cpu_rst_o) |-> cpu_pwr_o && !clk_stop_o && !mem_sr_o && !iso_o); // R8
  AST_STS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o <= 3'd4); // R10
  AST_WAKE_STS_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_sts_o) |-> state_o == 3'd4); // R10
  AST_IDLE_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd0 |-> !clk_stop_o && !mem_sr_o && cpu_pwr_o && !cpu_rst_o && !iso_o
                        && aux_pwr_o); // R11
endmodule

bind slp_seq slp_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sr_ack_i   (sr_ack_i),
  .pwr_good_i (pwr_good_i),
  .clk_stop_o (clk_stop_o),
  .mem_sr_o   (mem_sr_o),
  .cpu_pwr_o  (cpu_pwr_o),
  .cpu_rst_o  (cpu_rst_o),
  .iso_o      (iso_o),
  .aux_pwr_o  (aux_pwr_o),
  .state_o    (state_o),
  .wake_sts_o (wake_sts_o)
);

// File: tb/slp_seq_tb_top.sv
module slp_seq_tb_top;
  localparam int         MINC = 3;
  localparam logic [2:0] LC   = 3'd2;
  localparam logic [2:0] DC   = 3'd3;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctl_wr_i = 1'b0, ctl_en_i = 1'b0;
  logic [2:0] ctl_type_i = '0;
  logic       wake_any_i = 1'b0, wake_light_i = 1'b0;
  logic       sr_ack_i = 1'b0, pwr_good_i = 1'b1;
  logic       clk_stop_o, mem_sr_o, cpu_pwr_o, cpu_rst_o, iso_o, aux_pwr_o, wake_sts_o;
  logic [2:0] state_o;

  always #2 clk_i = ~clk_i;

  slp_seq #(.TYPE_W(3), .LIGHT_CODE(LC), .DEEP_CODE(DC), .MIN_CYC(MINC)) dut_i (.*);

  int errs = 0, chks = 0, n = 0;
  int ack_d = 0, pg_d = 0;
  logic [7:0] sr_h = '0, pg_h = '1;

  // memory and power-switch models: delayed copies of the requests
  always @(negedge clk_i) begin
    sr_h       <= {sr_h[6:0], mem_sr_o};
    pg_h       <= {pg_h[6:0], cpu_pwr_o};
    sr_ack_i   <= (ack_d == 0) ? mem_sr_o  : sr_h[ack_d-1];
    pwr_good_i <= (pg_d == 0)  ? cpu_pwr_o : pg_h[pg_d-1];
  end

  int t_clk_r, t_clk_f, t_sr_r, t_sr_f, t_cpu_r, t_cpu_f, t_iso_r, t_iso_f, t_aux_f, t_rst_f;
  int t_enter, t_sleep, t_exit, t_work;
  logic rst_at_on;
  logic p_clk = 0, p_sr = 0, p_cpu = 1, p_iso = 0, p_aux = 1, p_rst = 0;
  logic [2:0] p_st = '0;

  always @(negedge clk_i) begin
    n = n + 1;
    if (clk_stop_o && !p_clk) t_clk_r = n;
    if (!clk_stop_o && p_clk) t_clk_f = n;
    if (mem_sr_o && !p_sr) t_sr_r = n;
    if (!mem_sr_o && p_sr) t_sr_f = n;
    if (cpu_pwr_o && !p_cpu) begin t_cpu_r = n; rst_at_on = cpu_rst_o; end
    if (!cpu_pwr_o && p_cpu) t_cpu_f = n;
    if (iso_o && !p_iso) t_iso_r = n;
    if (!iso_o && p_iso) t_iso_f = n;
    if (!aux_pwr_o && p_aux) t_aux_f = n;
    if (!cpu_rst_o && p_rst) t_rst_f = n;
    if (state_o != p_st) begin
      if (state_o == 3'd1) t_enter = n;
      if (state_o == 3'd2 || state_o == 3'd3) t_sleep = n;
      if (state_o == 3'd4) t_exit = n;
      if (state_o == 3'd0) t_work = n;
    end
    p_clk = clk_stop_o; p_sr = mem_sr_o; p_cpu = cpu_pwr_o; p_iso = iso_o;
    p_aux = aux_pwr_o; p_rst = cpu_rst_o; p_st = state_o;
    if (n > 150000) begin
      errs = errs + 1;
      $display("FAIL watchdog: actual n=%0d expected <150000", n);
      $display("Result: errors=%0d of %0d checks", errs, chks + 1);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk_i);
    #1;
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    chks = chks + 1;
    if (!ok) begin
      errs = errs + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic wr(input logic [2:0] code, input logic en);
    ctl_wr_i = 1'b1; ctl_type_i = code; ctl_en_i = en;
    step();
    ctl_wr_i = 1'b0; ctl_en_i = 1'b0;
  endtask

  task automatic wait_st(input bit sleep_any, input logic [2:0] s, input string req);
    int k;
    k = 0;
    while (k < 400 && !(sleep_any ? (state_o == 3'd2 || state_o == 3'd3) : state_o == s)) begin
      step();
      k++;
    end
    chk(k < 400, req, state_o, s);
  endtask

  task automatic clear_stamps();
    t_clk_r = -1; t_clk_f = -1; t_sr_r = -1; t_sr_f = -1; t_cpu_r = -1; t_cpu_f = -1;
    t_iso_r = -1; t_iso_f = -1; t_aux_f = -1; t_rst_f = -1;
    t_enter = -1; t_sleep = -1; t_exit = -1; t_work = -1; rst_at_on = 1'b0;
  endtask

  task automatic run_seq(input bit deep, input int d, input int p, input bit early, input bit not_first);
    int t_wr, t_w, ak;
    ack_d = d; pg_d = p;
    repeat (10) step();
    clear_stamps();
    t_wr = n;
    wr(deep ? DC : LC, 1'b1);
    if (early) begin
      wait_st(1'b0, 3'd1, "R9 reach entering");
      wake_any_i = 1'b1; step(); wake_any_i = 1'b0;
    end
    if (not_first) begin
      wait_st(1'b0, 3'd1, "R10 entering");
      chk_eq("R10 wake_sts cleared on start", wake_sts_o, 0);
    end
    wait_st(1'b1, 3'd2, "R3/R6 reach sleep");
    ak = mx(MINC, d + 1);
    chk_eq("R1 entering two edges after write", t_enter - t_wr, 2);
    chk_eq("R10 sleep status code", state_o, deep ? 3 : 2);
    chk_eq("R4 reset held in sleep", cpu_rst_o, 1);
    if (!deep) begin
      chk_eq("R1 clk stop two edges after write", t_clk_r - t_wr, 2);
      chk_eq("R2 sr after clk stop", t_sr_r - t_clk_r, MINC);
      chk_eq("R2/R7 cpu off after sr ack", t_cpu_f - t_sr_r, ak);
      chk_eq("R3 light sleep after cpu off", t_sleep - t_cpu_f, MINC);
      chk_eq("R3 light rails", {clk_stop_o, mem_sr_o, cpu_pwr_o, aux_pwr_o, iso_o}, 5'b11010);
    end else begin
      chk_eq("R1 sr two edges after write", t_sr_r - t_wr, 2);
      chk_eq("R5/R7 iso after sr ack", t_iso_r - t_sr_r, ak);
      chk_eq("R5 power off after iso", t_cpu_f - t_iso_r, MINC);
      chk_eq("R5 clocks stop with power off", t_clk_r - t_cpu_f, 0);
      chk_eq("R5 aux off with power off", t_aux_f - t_cpu_f, 0);
      chk_eq("R6 deep sleep after power off", t_sleep - t_cpu_f, MINC);
      chk_eq("R6 deep rails", {clk_stop_o, mem_sr_o, cpu_pwr_o, aux_pwr_o, iso_o}, 5'b11001);
    end
    t_w = 0;
    if (!early) begin
      step(); step();
      if (deep) begin
        wake_light_i = 1'b1; step(); wake_light_i = 1'b0;
        step(); step();
        chk_eq("R6 light-only wake ignored in deep", state_o, 3);
        chk_eq("R6 aux stays off", aux_pwr_o, 0);
      end else if (d == 0 && p == 0) begin
        wr(DC, 1'b1);
        repeat (4) step();
        chk_eq("R1 write ignored while asleep", state_o, 2);
      end
      t_w = n;
      if (deep) wake_any_i = 1'b1; else wake_light_i = 1'b1;
      step();
      wake_any_i = 1'b0; wake_light_i = 1'b0;
    end
    wait_st(1'b0, 3'd0, "R8 back to working");
    repeat (3) step();
    if (early) chk_eq("R9 exit right after sleep", t_exit - t_sleep, 1);
    else       chk_eq("R10 exit one cycle after wake", t_exit - t_w, 1);
    chk_eq("R10 wake_sts set", wake_sts_o, 1);
    chk_eq("R8 power on at exit start", t_cpu_r - t_exit, 0);
    chk_eq("R4 reset high at power on", rst_at_on, 1);
    chk_eq("R8 clocks after power good", t_clk_f - t_cpu_r, mx(MINC, p + 1));
    chk_eq("R8 sr drop after clocks", t_sr_f - t_clk_f, MINC);
    if (deep) begin
      chk_eq("R8 iso drop after ack low", t_iso_f - t_sr_f, ak);
      chk_eq("R8 reset release after iso", t_rst_f - t_iso_f, MINC);
    end else begin
      chk_eq("R8 reset release after sr", t_rst_f - t_sr_f, ak + MINC);
    end
    chk_eq("R10 working with reset release", t_work - t_rst_f, 0);
  endtask

  initial begin
    int nrun;
    repeat (3) step();
    rst_ni = 1'b1;
    repeat (2) step();
    chk_eq("R11 reset status", state_o, 0);
    chk_eq("R11 reset outputs",
           {clk_stop_o, mem_sr_o, cpu_pwr_o, cpu_rst_o, iso_o, aux_pwr_o, wake_sts_o},
           7'b0010010);

    // R1: every unsupported code and every disabled write is ignored
    for (int c = 0; c < 8; c++) begin
      for (int e = 0; e < 2; e++) begin
        if (e == 1 && (c == int'(LC) || c == int'(DC))) continue;
        wr(3'(c), e[0]);
        repeat (6) step();
        chk_eq("R1 ignored write status", state_o, 0);
        chk_eq("R1 ignored write outputs", {clk_stop_o, mem_sr_o, cpu_pwr_o, iso_o}, 4'b0010);
      end
    end

    // R11: wakes in working status do nothing
    wake_any_i = 1'b1; wake_light_i = 1'b1;
    repeat (3) step();
    wake_any_i = 1'b0; wake_light_i = 1'b0;
    repeat (3) step();
    chk_eq("R11 wake ignored when working", state_o, 0);
    chk_eq("R11 no wake flag when working", wake_sts_o, 0);
    chk_eq("R11 cpu not reset", cpu_rst_o, 0);

    nrun = 0;
    for (int dp = 0; dp < 2; dp++)
      for (int di = 0; di < 4; di++)
        for (int pi = 0; pi < 3; pi++)
          for (int ei = 0; ei < 2; ei++) begin
            run_seq(dp[0], (di == 3) ? 5 : di, pi * 2, ei[0], nrun > 0);
            nrun++;
          end

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule